// File: doc/BRIEF.md
# NRZI Channel Bit Serialiser

This block turns 16-bit data words into a serial NRZI line stream for a slow half-duplex packet radio modem. An upstream framer, which has already produced flags and inserted stuffed bits, offers words with a valid/ready handshake. A channel-bit strobe (`tick`) paces the block. Each tick moves exactly one bit onto the line, least significant bit first.

The current word sits in a shift register one bit wider than the word. A marker 1 sits above the data. When the register has shifted down to the marker alone, or is empty after reset, the block asks for a new word. Each line bit is computed one tick ahead and held in a register. On every tick the bit computed on the previous tick is driven first, and only then is the next bit derived from the register. If the framer has no word when one is asked for, an all-ones word is loaded, so the line holds its level for a full word time. When `tx_en` is low, the line is held at a fixed idle level and the word register is emptied.

Top module: `nrzi_tx`

## Requirements
- R1: A synchronous active-high `rst` drives `line_out` to 0 and `word_ready` to 0, clears the held line level to 0 and empties the word register, so the first enabled tick afterwards requests a word.
- R2: `word_ready` is 1 only in a cycle with `tick`=1 and `tx_en`=1 while the word register is empty. It stays high for exactly that one cycle. A word is taken when `word_valid` is 1 in that cycle.
- R3: A loaded word supplies one bit per enabled tick, bit 0 first and bit 15 last. The next request comes on the 17th enabled tick counted from the loading tick, which is itself tick 1.
- R4: Line coding is NRZI. A data bit of 0 inverts the held line level, and a data bit of 1 leaves it unchanged.
- R5: `line_out` changes on the clock edge of an enabled tick to the level computed on the previous enabled tick. The level for data bit k therefore appears one tick after the tick that consumes bit k.
- R6: If `word_valid` is 0 on a requesting tick, an all-ones word is loaded. The line holds its level for those 16 ticks, and the next request comes 16 enabled ticks later.
- R7: While `tx_en` is 0, `line_out` equals the idle level 0 from the next clock edge on, and `word_ready` is 0. The word register is emptied, and the held line level is kept for the next enabled tick.
- R8: In cycles without `tick`, `line_out` keeps its value while `tx_en` is 1, and `word_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit enable. When low, the line idles |
| tick | input | 1 | One-cycle channel-bit strobe |
| word_data | input | 16 | Data word from the framer, sent LSB first |
| word_valid | input | 1 | `word_data` holds a word |
| word_ready | output | 1 | Word taken in this cycle (when valid) |
| line_out | output | 1 | Registered NRZI line bit |

## Verification
The assertions assume that `tick` is a single-cycle strobe, or at least that a requesting tick is followed by a full word of non-requesting ticks. They also assume that `tx_en` only changes on a clock edge, so that enable and flush never act in the same cycle. The bench drives `tick` for one cycle, then leaves at least one quiet cycle, and changes `tx_en` and the word inputs only away from the edge. It sweeps a set of computed words, including all-zeros, all-ones and alternating patterns. It withholds the word on some requests, and it drops `tx_en` in the middle of a word, so the register empties at a point other than a word boundary.

// File: rtl/nrzi_tx_pkg.sv
package nrzi_tx_pkg;
  // NRZI rule: a 0 inverts the level, a 1 keeps it
  function automatic logic nrzi_next(input logic level, input logic data_bit);
    return data_bit ? level : ~level;
  endfunction
endpackage

// File: rtl/nrzi_tx_shifter.sv
module nrzi_tx_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              flush,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              out_ready,
  output logic              bit_now
);
  localparam int SR_W = DATA_W + 1;

  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] load_val;
  logic [SR_W-1:0] cur;
  logic            empty;

  // empty when only the marker (or nothing) is left
  assign empty    = (sr_q[SR_W-1:1] == '0);
  assign load_val = {1'b1, (in_valid ? in_data : {DATA_W{1'b1}})};
  assign cur      = empty ? load_val : sr_q;
  assign bit_now  = cur[0];
  assign out_ready = adv & empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (flush) begin
      sr_q <= '0;
    end else if (adv) begin
      sr_q <= cur >> 1;
    end
  end

  // after an advancing tick the register keeps the marker
  assert_marker_kept_R3: assert property (@(posedge clk) disable iff (rst)
    adv |=> (sr_q != '0));

  // a request is never followed by another one on the next cycle
  assert_no_back_request_R2: assert property (@(posedge clk) disable iff (rst)
    out_ready |=> !out_ready);

  // a disabled cycle leaves the register empty
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
    flush |=> (sr_q == '0));
endmodule

// File: rtl/nrzi_tx_encoder.sv
module nrzi_tx_encoder #(
  parameter logic IDLE_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic flush,
  input  logic bit_in,
  output logic line_out
);
  import nrzi_tx_pkg::*;

  logic lvl_q;
  logic line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= 1'b0;
      line_q <= 1'b0;
    end else if (flush) begin
      line_q <= IDLE_LEVEL;
    end else if (adv) begin
      line_q <= lvl_q;                      // drive the earlier result first
      lvl_q  <= nrzi_next(lvl_q, bit_in);   // then prepare the next one
    end
  end

  assign line_out = line_q;

  // a 1 bit must not change the held level
  assert_one_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && bit_in) |=> $stable(lvl_q));

  // a 0 bit must invert the held level
  assert_zero_toggles_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && !bit_in) |=> (lvl_q != $past(lvl_q)));

  // the line only moves on a tick or when idled
  assert_line_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
    (!adv && !flush) |=> $stable(line_q));
endmodule

// File: rtl/nrzi_tx.sv
module nrzi_tx #(
  parameter int   DATA_W     = 16,
  parameter logic IDLE_LEVEL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              tick,
  input  logic [DATA_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  output logic              line_out
);
  logic adv;
  logic flush;
  logic cur_bit;

  assign adv   = tick & tx_en;
  assign flush = ~tx_en;

  nrzi_tx_shifter #(.DATA_W(DATA_W)) shift_i (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .flush    (flush),
    .in_data  (word_data),
    .in_valid (word_valid),
    .out_ready(word_ready),
    .bit_now  (cur_bit)
  );

  nrzi_tx_encoder #(.IDLE_LEVEL(IDLE_LEVEL)) enc_i (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .flush   (flush),
    .bit_in  (cur_bit),
    .line_out(line_out)
  );

  assert_idle_level_R7: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (line_out == IDLE_LEVEL));

  assert_ready_needs_tick_R2: assert property (@(posedge clk) disable iff (rst)
    word_ready |-> (tick && tx_en));

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!line_out));
endmodule

// File: tb/nrzi_tx_tb.sv
module nrzi_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_en = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] word_data = '0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic        line_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // bench model state
  logic        m_lvl = 1'b0;
  int          m_pos = 0;
  logic [15:0] m_buf = '0;
  logic        m_fill = 1'b0;
  int          slot = 0;

  always #10 clk = ~clk;

  nrzi_tx dut_i (
    .clk(clk), .rst(rst), .tx_en(tx_en), .tick(tick),
    .word_data(word_data), .word_valid(word_valid),
    .word_ready(word_ready), .line_out(line_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input int s);
    case (s)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'hA5A5;
      3: return 16'h8001;
      default: return 16'(s * 40503) ^ 16'(s << 5);
    endcase
  endfunction

  // one enabled or disabled tick, then a quiet cycle
  task automatic do_tick();
    logic exp_rdy;
    logic exp_line;
    logic b;
    string lreq;
    @(negedge clk);
    word_valid = ((slot % 9) != 4);
    word_data  = word_of(slot);
    tick = 1'b1;
    #1;
    exp_rdy = tx_en && (m_pos == 0);
    chk(word_ready == exp_rdy, exp_rdy ? "R2" : "R3", word_ready, exp_rdy);
    lreq = "R4";
    if (tx_en) begin
      if (m_pos == 0) begin
        m_fill = !word_valid;
        m_buf  = word_valid ? word_data : 16'hFFFF;
        m_pos  = 16;
        slot++;
        lreq = "R5";
      end
      if (m_fill) lreq = "R6";
      b = m_buf[16 - m_pos];
      m_pos--;
      exp_line = m_lvl;
      m_lvl = b ? m_lvl : ~m_lvl;
    end else begin
      exp_line = 1'b0;
      lreq = "R7";
    end
    @(negedge clk);
    tick = 1'b0;
    #1;
    chk(line_out == exp_line, lreq, line_out, exp_line);
    // quiet cycle
    @(negedge clk);
    chk(line_out == exp_line, "R8", line_out, exp_line);
    chk(word_ready == 1'b0, "R8", word_ready, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(line_out == 1'b0, "R1", line_out, 0);
    chk(word_ready == 1'b0, "R1", word_ready, 0);
    rst = 1'b0;
    tx_en = 1'b1;
    @(negedge clk);
    chk(line_out == 1'b0, "R1", line_out, 0);
    for (int i = 0; i < 16 * 40; i++) do_tick();
    // drop enable in the middle of a word
    for (int i = 0; i < 5; i++) do_tick();
    @(negedge clk);
    tx_en = 1'b0;
    m_pos = 0;
    @(negedge clk);
    chk(line_out == 1'b0, "R7", line_out, 0);
    for (int i = 0; i < 3; i++) do_tick();
    @(negedge clk);
    tx_en = 1'b1;
    for (int i = 0; i < 16 * 30; i++) do_tick();
    // reset mid-stream
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_lvl = 1'b0;
    m_pos = 0;
    chk(line_out == 1'b0, "R1", line_out, 0);
    for (int i = 0; i < 40; i++) do_tick();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule